// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that software cannot switch off once it is running. A slow, free-running tick acts as the watchdog clock. A programmable prescaler divides that tick down. Each divided tick steps a 12-bit down-counter. When the counter has run out, the block raises a reset request that lasts one clock cycle. Software must refresh the counter often enough to keep that request from firing.

All control goes through a small register bus, and every action is gated by a 16-bit code written to a key register. One code starts the timer. A second code refreshes it. A third code opens the divider and period registers to writes.

A write to either of those two configuration registers does not take effect at once. It is held as pending for a fixed number of watchdog ticks, which models the crossing into the slow domain. A status flag for that register stays up for the whole of this time. The new setting is applied in the same cycle that the flag drops.

Top module: `kwd_watchdog`

## Requirements
- R1: After reset the status register (offset 0x0C) reads 0, the prescaler register (offset 0x04) reads 0, the reload register (offset 0x08) reads 0xFFF, and `wdg_reset` is low.
- R2: While the configuration is locked, writes to the prescaler register and to the reload register are ignored. The readback value and the status do not change.
- R3: Writing 0x5555 to the key register (offset 0x00) unlocks the configuration.
  - A prescaler write then reads back in bits [2:0] and sets status bit 0.
  - A reload write then reads back in bits [11:0] and sets status bit 1.
- R4: Any write to the key register other than 0x5555 locks the configuration again.
- R5: A status flag clears on the SYNC_TICKS-th watchdog tick after its register was last written (default 3). The written value becomes the active setting in that same cycle.
- R6: Until 0xCCCC has been written to the key register, the counter does not run and `wdg_reset` never rises.
- R7: After a start write (0xCCCC) or a refresh write (0xAAAA), `wdg_reset` pulses after exactly (reload + 1) × div watchdog ticks.
  - For prescaler codes 0 to 6, div is 4 × 2^code.
  - Code 7 also gives a div of 256.
- R8: A refresh write (0xAAAA) reloads the counter and restarts the divider, so refreshing more often than the period keeps `wdg_reset` low.
- R9: On expiry, `wdg_reset` is high for exactly one clock cycle. The counter then reloads by itself, and the next pulse comes one full period later.
- R10: Once the timer has started, no key write stops it. Only the system reset does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| wd_tick | input | 1 | One-cycle enable for each tick of the low-speed watchdog clock |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`; the key register reads as zero |
| wdg_reset | output | 1 | One-cycle reset request on expiry |

## Verification
The bench measures the expiry time in watchdog ticks for several divider codes, including code 7 and a reload of zero. A divider decode or reload load that is off by one would give a count that differs from (reload + 1) × div.

It checks that locked writes leave the readback unchanged and that a stray key code locks the configuration again. A design with a sticky unlock would accept the later write.

It checks the pending flags tick by tick. A flag that clears early or late shows up on the tick before or the tick after it should.

It also confirms that ticks before the start write produce no pulse, that the pulse lasts one cycle and repeats, and that key codes after the start do not stop the timer.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 32;
    localparam int PSC_W     = 3;
    localparam int RELOAD_W  = 12;
    localparam int DIVCNT_W  = 8;
    localparam int DIV_W     = DIVCNT_W + 1;

    localparam logic [15:0] KEY_START  = 16'hCCCC;
    localparam logic [15:0] KEY_KICK   = 16'hAAAA;
    localparam logic [15:0] KEY_UNLOCK = 16'h5555;

    typedef enum logic [1:0] {
        SEL_KEY    = 2'd0,
        SEL_PSC    = 2'd1,
        SEL_RELOAD = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    function automatic logic [DIV_W-1:0] psc_divisor(input logic [PSC_W-1:0] code);
        logic [DIV_W-1:0] d;
        if (code == 3'd7) d = 9'd256;
        else              d = 9'd4 << code;
        return d;
    endfunction
endpackage

// File: rtl/wdg_sync_slot.sv
module wdg_sync_slot #(
    parameter int              W          = 12,
    parameter logic [W-1:0]    RST_VAL    = '0,
    parameter int              SYNC_TICKS = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active,
    output logic         pending
);
    localparam int CW = $clog2(SYNC_TICKS + 1);
    localparam logic [CW-1:0] CNT_INIT = CW'(SYNC_TICKS);

    typedef struct packed {
        logic [W-1:0]  shadow;
        logic [W-1:0]  active;
        logic          pend;
        logic [CW-1:0] cnt;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr) begin
            s_d.shadow = wdata;
            s_d.pend   = 1'b1;
            s_d.cnt    = CNT_INIT;
        end else if (s_q.pend && tick) begin
            if (s_q.cnt == CW'(1)) begin
                s_d.pend   = 1'b0;
                s_d.active = s_q.shadow;
                s_d.cnt    = '0;
            end else begin
                s_d.cnt = s_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.shadow <= RST_VAL;
            s_q.active <= RST_VAL;
            s_q.pend   <= 1'b0;
            s_q.cnt    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign shadow  = s_q.shadow;
    assign active  = s_q.active;
    assign pending = s_q.pend;

    // Requirement R5: the new value becomes active when the flag drops
    assert_apply_on_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.pend) |-> (s_q.active == $past(s_q.shadow)));

    // Requirement R5: a tick with no write never raises the flag
    assert_flag_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.pend && !wr) |=> !s_q.pend);
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int SYNC_TICKS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wd_tick,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                started,
    output logic                kick,
    output logic [PSC_W-1:0]    psc_active,
    output logic [RELOAD_W-1:0] reload_active
);
    typedef struct packed {
        logic started;
        logic unlocked;
    } ctl_t;

    ctl_t c_d, c_q;

    reg_sel_e             sel;
    logic                 key_wr;
    logic [15:0]          key_val;
    logic                 psc_wr, rld_wr;
    logic [PSC_W-1:0]     psc_shadow;
    logic [RELOAD_W-1:0]  rld_shadow;
    logic                 psc_pend, rld_pend;
    logic                 unused_bits;

    assign sel     = reg_sel_e'(bus_addr[3:2]);
    assign key_val = bus_wdata[15:0];
    assign key_wr  = bus_we && (sel == SEL_KEY);
    assign psc_wr  = bus_we && (sel == SEL_PSC) && c_q.unlocked;
    assign rld_wr  = bus_we && (sel == SEL_RELOAD) && c_q.unlocked;
    assign kick    = key_wr && ((key_val == KEY_START) || (key_val == KEY_KICK));
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:16]};

    always_comb begin
        c_d = c_q;
        if (key_wr) begin
            c_d.unlocked = (key_val == KEY_UNLOCK);
            if (key_val == KEY_START) c_d.started = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.started  <= 1'b0;
            c_q.unlocked <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    wdg_sync_slot #(.W(PSC_W), .RST_VAL(3'd0), .SYNC_TICKS(SYNC_TICKS)) psc_slot_i (
        .clk(clk), .rst_n(rst_n), .tick(wd_tick), .wr(psc_wr),
        .wdata(bus_wdata[PSC_W-1:0]), .shadow(psc_shadow),
        .active(psc_active), .pending(psc_pend)
    );

    wdg_sync_slot #(.W(RELOAD_W), .RST_VAL(12'hFFF), .SYNC_TICKS(SYNC_TICKS)) rld_slot_i (
        .clk(clk), .rst_n(rst_n), .tick(wd_tick), .wr(rld_wr),
        .wdata(bus_wdata[RELOAD_W-1:0]), .shadow(rld_shadow),
        .active(reload_active), .pending(rld_pend)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_PSC:    bus_rdata[PSC_W-1:0]    = psc_shadow;
            SEL_RELOAD: bus_rdata[RELOAD_W-1:0] = rld_shadow;
            SEL_STATUS: bus_rdata[1:0]          = {rld_pend, psc_pend};
            default:    bus_rdata = '0;
        endcase
    end

    assign started = c_q.started;

    // Requirement R2: locked writes leave the prescaler shadow untouched
    assert_locked_psc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_PSC && !c_q.unlocked) |=> $stable(psc_shadow));

    // Requirement R2: locked writes leave the reload shadow untouched
    assert_locked_rld_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_RELOAD && !c_q.unlocked) |=> $stable(rld_shadow));

    // Requirement R4: a key other than the unlock code relocks
    assert_relock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && key_val != KEY_UNLOCK) |=> !c_q.unlocked);

    // Requirement R10: a started timer stays started
    assert_start_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.started |=> c_q.started);
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             clear,
    input  logic [PSC_W-1:0] code,
    output logic             step
);
    typedef struct packed {
        logic [DIVCNT_W-1:0] cnt;
    } psc_t;

    psc_t p_d, p_q;
    logic [DIV_W-1:0] last;
    logic             wrap;

    assign last = psc_divisor(code) - DIV_W'(1);
    assign wrap = {1'b0, p_q.cnt} >= last;
    assign step = run && tick && !clear && wrap;

    always_comb begin
        p_d = p_q;
        if (clear) begin
            p_d.cnt = '0;
        end else if (run && tick) begin
            if (wrap) p_d.cnt = '0;
            else      p_d.cnt = p_q.cnt + DIVCNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q.cnt <= '0;
        else        p_q <= p_d;
    end

    // Requirement R6: the divider is frozen while the timer is not running
    assert_frozen_before_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(p_q.cnt));
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  logic [RELOAD_W-1:0] reload,
    output logic                expire
);
    typedef struct packed {
        logic [RELOAD_W-1:0] cnt;
        logic                fire;
    } cnt_t;

    cnt_t k_d, k_q;

    always_comb begin
        k_d      = k_q;
        k_d.fire = 1'b0;
        if (load) begin
            k_d.cnt = reload;
        end else if (step) begin
            if (k_q.cnt == '0) begin
                k_d.fire = 1'b1;
                k_d.cnt  = reload;
            end else begin
                k_d.cnt = k_q.cnt - RELOAD_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q.cnt  <= '1;
            k_q.fire <= 1'b0;
        end else begin
            k_q <= k_d;
        end
    end

    assign expire = k_q.fire;

    // Requirement R9: the reset request lasts a single cycle
    assert_pulse_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        k_q.fire |=> !k_q.fire);
endmodule

// File: rtl/kwd_watchdog.sv
module kwd_watchdog
    import wdg_pkg::*;
#(
    parameter int SYNC_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wd_tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdg_reset
);
    logic                started, kick, step;
    logic [PSC_W-1:0]    psc_active;
    logic [RELOAD_W-1:0] reload_active;

    wdg_regs #(.SYNC_TICKS(SYNC_TICKS)) regs_i (
        .clk(clk), .rst_n(rst_n), .wd_tick(wd_tick),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .started(started), .kick(kick),
        .psc_active(psc_active), .reload_active(reload_active)
    );

    wdg_prescaler psc_i (
        .clk(clk), .rst_n(rst_n), .tick(wd_tick), .run(started),
        .clear(kick), .code(psc_active), .step(step)
    );

    wdg_counter cnt_i (
        .clk(clk), .rst_n(rst_n), .load(kick), .step(step),
        .reload(reload_active), .expire(wdg_reset)
    );

    // Requirement R6: no reset request before the start key
    assert_no_reset_before_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wdg_reset |-> started);
endmodule

// File: tb/kwd_watchdog_tb_top.sv
module kwd_watchdog_tb_top;
    import wdg_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wd_tick = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              wdg_reset;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    kwd_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .wd_tick(wd_tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdg_reset(wdg_reset)
    );

    localparam logic [3:0] A_KEY = 4'h0, A_PSC = 4'h4, A_RLD = 4'h8, A_STS = 4'hC;

    // code, reload, expected ticks to expiry
    localparam logic [46:0] VECS [0:5] = '{
        {3'd0, 12'd3, 32'd16},
        {3'd1, 12'd2, 32'd24},
        {3'd2, 12'd0, 32'd16},
        {3'd7, 12'd0, 32'd256},
        {3'd6, 12'd1, 32'd512},
        {3'd3, 12'd5, 32'd192}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    // One tick cycle then one idle cycle; reports pulse after the tick and level after idle
    task automatic tick_once(output bit got, output bit after);
        @(negedge clk);
        wd_tick = 1'b1;
        @(negedge clk);
        wd_tick = 1'b0;
        got = wdg_reset;
        @(negedge clk);
        after = wdg_reset;
    endtask

    task automatic ticks_no_pulse(input int n, output int pulses);
        bit g, a;
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            tick_once(g, a);
            if (g || a) pulses++;
        end
    endtask

    task automatic count_to_pulse(input int limit, output int n, output bit after);
        bit g;
        n = 0;
        after = 1'b0;
        while (n <= limit) begin
            tick_once(g, after);
            n++;
            if (g) break;
        end
    endtask

    task automatic configure(input logic [2:0] code, input logic [11:0] rl);
        int p;
        wr(A_KEY, 32'h5555);
        wr(A_PSC, {29'd0, code});
        wr(A_RLD, {20'd0, rl});
        wr(A_KEY, 32'h0);
        ticks_no_pulse(3, p);
        check("R5", "config ticks pulse-free", p, 0);
    endtask

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog timeout: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int v, p, n;
        bit g, a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_STS, v); check("R1", "status", v, 0);
        rd(A_PSC, v); check("R1", "prescaler", v, 0);
        rd(A_RLD, v); check("R1", "reload", v, 12'hFFF);
        rd(A_KEY, v); check("R1", "key reads zero", v, 0);
        check("R1", "wdg_reset", int'(wdg_reset), 0);

        // R2 locked writes ignored
        wr(A_PSC, 32'd3);
        wr(A_RLD, 32'd7);
        rd(A_PSC, v); check("R2", "locked prescaler", v, 0);
        rd(A_RLD, v); check("R2", "locked reload", v, 12'hFFF);
        rd(A_STS, v); check("R2", "locked status", v, 0);

        // R3 unlock and write
        wr(A_KEY, 32'h5555);
        wr(A_PSC, 32'd2);
        rd(A_PSC, v); check("R3", "unlocked prescaler", v, 2);
        rd(A_STS, v); check("R3", "status bit0", v, 1);

        // R4 stray key relocks
        wr(A_KEY, 32'h1234);
        wr(A_PSC, 32'd5);
        rd(A_PSC, v); check("R4", "relocked prescaler", v, 2);

        // R5 flag clears on third tick
        tick_once(g, a); tick_once(g, a);
        rd(A_STS, v); check("R5", "flag after 2 ticks", v, 1);
        tick_once(g, a);
        rd(A_STS, v); check("R5", "flag after 3 ticks", v, 0);

        // R3 reload write sets bit 1; R6 no pulse before start
        wr(A_KEY, 32'h5555);
        wr(A_RLD, 32'd0);
        rd(A_RLD, v); check("R3", "unlocked reload", v, 0);
        rd(A_STS, v); check("R3", "status bit1", v, 2);
        wr(A_KEY, 32'h0);
        ticks_no_pulse(60, p);
        check("R6", "pulses before start", p, 0);
        wr(A_KEY, 32'hAAAA);
        ticks_no_pulse(40, p);
        check("R6", "pulses after refresh only", p, 0);

        // R7 table of periods
        for (int i = 0; i < 6; i++) begin
            logic [2:0]  c;
            logic [11:0] r;
            int          e;
            c = VECS[i][46:44];
            r = VECS[i][43:32];
            e = int'(VECS[i][31:0]);
            if (i > 0) wr(A_KEY, 32'hAAAA);
            configure(c, r);
            wr(A_KEY, (i == 0) ? 32'hCCCC : 32'hAAAA);
            count_to_pulse(2 * e + 8, n, a);
            check("R7", $sformatf("period code %0d reload %0d", c, r), n, e);
            check("R9", "pulse width", int'(a), 0);
        end

        // R9 auto reload repeats period
        count_to_pulse(400, n, a);
        check("R9", "repeat period", n, 192);
        check("R9", "repeat pulse width", int'(a), 0);

        // R8 refresh holds off expiry
        wr(A_KEY, 32'hAAAA);
        configure(3'd0, 12'd3);
        wr(A_KEY, 32'hAAAA);
        p = 0;
        for (int k = 0; k < 5; k++) begin
            int q;
            ticks_no_pulse(10, q);
            p += q;
            wr(A_KEY, 32'hAAAA);
        end
        check("R8", "pulses while refreshed", p, 0);
        count_to_pulse(40, n, a);
        check("R8", "expiry after last refresh", n, 16);

        // R10 no key stops it
        wr(A_KEY, 32'hAAAA);
        wr(A_KEY, 32'h0000);
        wr(A_KEY, 32'h5555);
        wr(A_KEY, 32'h1234);
        wr(A_KEY, 32'hFFFF);
        count_to_pulse(40, n, a);
        check("R10", "still expires", n, 16);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule